// File: doc/BRIEF.md
# MESI Snooping Line Controller

This block keeps the coherence state of a small direct-mapped write-back cache that sits on a shared snooping bus. Each line is Invalid, Shared, Exclusive (a clean sole copy) or Modified (dirty). Processor requests arrive on a valid/ready handshake. Hits complete without bus traffic. Misses and upgrades raise bus requests that are held until an external arbiter grants them. A dirty victim is written back before its replacement is fetched.

The block also watches every transaction that other agents put on the bus. It answers each one with a registered shared vote, a flush indication for dirty data, and an optional clean supply indication for cache-to-cache transfer. On its own read it samples the wired-OR shared line one cycle after its grant. It then installs the line as Shared or Exclusive according to that sample.

Back-pressure rules: a request is taken only in a cycle where `cpu_req_valid` and `cpu_req_ready` are both high. `cpu_req_ready` drops while a transaction is outstanding and in any cycle that carries a snoop. A bus request stays asserted with stable kind and address until `bus_gnt` is sampled high.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. `cpu_req_ready` is high and `bus_req_valid`, `cpu_done`, `snp_shared`, `snp_flush` and `snp_supply` are low. A snooped read gets no response.
- R2: A read miss raises `bus_req_valid` with kind 1 (read) in the cycle after acceptance. Kind encoding is 0 idle, 1 read, 2 read-exclusive, 3 write-back. The request holds its kind and address until granted.
- R3: The shared line is sampled in the cycle after the read grant. If it is high the line becomes Shared, otherwise Exclusive. `cpu_done` pulses in the cycle after that sample.
- R4: A read or write hit in Modified or Exclusive, or a read hit in Shared, pulses `cpu_done` in the cycle after acceptance and raises no bus request.
- R5: A write hit in Exclusive turns the line Modified without any bus request.
- R6: A write to a Shared or absent line issues kind 2 (read-exclusive) and installs the line Modified. `cpu_done` pulses in the cycle after the grant.
- R7: Snoop responses are registered and appear in the cycle after `snp_valid`. `snp_shared` is high for a snooped read that hits a valid line.
- R8: A snooped read of a Modified line raises `snp_flush` and leaves the line Shared. A snooped read of an Exclusive line leaves it Shared.
- R9: A snooped read-exclusive invalidates a hit line. It raises `snp_flush` only if the line was Modified.
- R10: With cache-to-cache transfer enabled, a snooped read raises `snp_supply` for an Exclusive line always, and for a Shared line only when `c2c_pick` is high. It never does so for a Modified line.
- R11: A miss whose victim is Modified first issues kind 3 with the victim's address, then the fill request. A Shared or Exclusive victim is dropped silently.
- R12: `cpu_req_ready` is low while a transaction is outstanding and in every cycle in which `snp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Controller can take a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address of the request |
| cpu_done | output | 1 | Request completed (one-cycle pulse) |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_kind | output | 2 | 1 read, 2 read-exclusive, 3 write-back |
| bus_req_addr | output | ADDR_W | Line address of the bus transaction |
| bus_gnt | input | 1 | Arbiter grant; the address phase is this cycle |
| bus_shared_in | input | 1 | Wired-OR shared line from the other caches |
| snp_valid | input | 1 | A transaction from another agent is on the bus |
| snp_kind | input | 2 | Kind of the snooped transaction |
| snp_addr | input | ADDR_W | Line address of the snooped transaction |
| c2c_pick | input | 1 | This cache is the chosen supplier of shared clean data |
| snp_shared | output | 1 | Shared vote for the snooped read |
| snp_flush | output | 1 | Dirty data must be flushed for the snoop |
| snp_supply | output | 1 | Clean data supplied cache-to-cache |

## Verification
Hit completion is due one cycle after the accepting edge. A read fill completes two cycles after its grant edge: one cycle to sample the shared line and one for the done register. A read-exclusive fill completes one cycle after the grant. Snoop answers are due one cycle after the snoop cycle. The bench drives and samples on falling edges, so each check lands in exactly the cycle where its result is due. Line states are observed only through later snoop answers at the ports: shared, flush and supply together tell Invalid, Shared, Exclusive and Modified apart.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_RD   = 2'd1,
    BK_RDX  = 2'd2,
    BK_WB   = 2'd3
  } bus_kind_e;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
  import mesi_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int IDX_W = 2,
  parameter int TAG_W = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [IDX_W-1:0]           cpu_idx,
  input  logic [IDX_W-1:0]           snp_idx,
  input  logic                       fill_we,
  input  logic [IDX_W-1:0]           fill_idx,
  input  logic [TAG_W-1:0]           fill_tag,
  input  line_st_e                   fill_st,
  input  logic                       snp_we,
  input  line_st_e                   snp_st,
  output logic [TAG_W-1:0]           cpu_tag,
  output line_st_e                   cpu_st,
  output logic [TAG_W-1:0]           snp_tag,
  output line_st_e                   snp_cur_st,
  output logic [SETS-1:0][1:0]       st_all
);
  logic [SETS-1:0][TAG_W-1:0] tag_all;

  for (genvar g = 0; g < SETS; g++) begin : g_set
    logic [TAG_W-1:0] tag_q;
    line_st_e         st_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_q <= '0;
        st_q  <= ST_I;
      end else if (fill_we && fill_idx == IDX_W'(g)) begin
        tag_q <= fill_tag;
        st_q  <= fill_st;
      end else if (snp_we && snp_idx == IDX_W'(g)) begin
        st_q  <= snp_st;
      end
    end
    assign tag_all[g] = tag_q;
    assign st_all[g]  = st_q;
  end

  assign cpu_tag    = tag_all[cpu_idx];
  assign cpu_st     = line_st_e'(st_all[cpu_idx]);
  assign snp_tag    = tag_all[snp_idx];
  assign snp_cur_st = line_st_e'(st_all[snp_idx]);
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
  import mesi_pkg::*;
#(
  parameter int  TAG_W  = 6,
  parameter bit  C2C_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snp_valid,
  input  logic [1:0]       snp_kind,
  input  logic [TAG_W-1:0] snp_tag_in,
  input  logic             c2c_pick,
  input  logic [TAG_W-1:0] line_tag,
  input  line_st_e         line_st,
  output logic             snp_we,
  output line_st_e         snp_new_st,
  output logic             snp_shared,
  output logic             snp_flush,
  output logic             snp_supply
);
  logic hit, is_rd, is_rdx;

  assign hit    = snp_valid && (line_st != ST_I) && (line_tag == snp_tag_in);
  assign is_rd  = (snp_kind == BK_RD);
  assign is_rdx = (snp_kind == BK_RDX);

  always_comb begin
    snp_we     = 1'b0;
    snp_new_st = line_st;
    if (hit && is_rd && (line_st == ST_M || line_st == ST_E)) begin
      snp_we     = 1'b1;
      snp_new_st = ST_S;
    end else if (hit && is_rdx) begin
      snp_we     = 1'b1;
      snp_new_st = ST_I;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snp_shared <= 1'b0;
      snp_flush  <= 1'b0;
      snp_supply <= 1'b0;
    end else begin
      snp_shared <= hit && is_rd;
      snp_flush  <= hit && (is_rd || is_rdx) && (line_st == ST_M);
      snp_supply <= C2C_EN && hit && is_rd &&
                    ((line_st == ST_E) || (line_st == ST_S && c2c_pick));
    end
  end

  // R7
  flush_after_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_flush || snp_shared || snp_supply) |-> $past(snp_valid));
endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_req_ready,
  output logic              cpu_done,
  input  logic              snp_valid,
  input  logic              bus_gnt,
  input  logic              bus_shared_in,
  input  logic [TAG_W-1:0]  look_tag,
  input  line_st_e          look_st,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_kind,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic              fill_we,
  output logic [IDX_W-1:0]  fill_idx,
  output logic [TAG_W-1:0]  fill_tag,
  output line_st_e          fill_st,
  output logic              sampling
);
  typedef enum logic [1:0] {F_IDLE, F_WB, F_REQ, F_SAMPLE} fsm_e;

  fsm_e              fsm_q;
  logic [ADDR_W-1:0] addr_q;
  logic              write_q;
  logic [TAG_W-1:0]  victim_tag_q;
  logic              done_q;
  logic              accept, hit, fast;
  logic [TAG_W-1:0]  req_tag;

  assign req_tag       = cpu_req_addr[ADDR_W-1:IDX_W];
  assign cpu_req_ready = (fsm_q == F_IDLE) && !snp_valid;
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign hit           = (look_st != ST_I) && (look_tag == req_tag);
  assign fast          = hit && (look_st == ST_M || look_st == ST_E ||
                                 (look_st == ST_S && !cpu_req_write));
  assign cpu_done      = done_q;
  assign sampling      = (fsm_q == F_SAMPLE);

  always_comb begin
    bus_req_valid = 1'b0;
    bus_req_kind  = BK_NONE;
    bus_req_addr  = addr_q;
    fill_we       = 1'b0;
    fill_idx      = addr_q[IDX_W-1:0];
    fill_tag      = addr_q[ADDR_W-1:IDX_W];
    fill_st       = ST_M;
    case (fsm_q)
      F_IDLE: begin
        fill_idx = cpu_req_addr[IDX_W-1:0];
        fill_tag = req_tag;
        fill_we  = accept && fast && cpu_req_write && (look_st == ST_E);
      end
      F_WB: begin
        bus_req_valid = 1'b1;
        bus_req_kind  = BK_WB;
        bus_req_addr  = {victim_tag_q, addr_q[IDX_W-1:0]};
      end
      F_REQ: begin
        bus_req_valid = 1'b1;
        bus_req_kind  = write_q ? BK_RDX : BK_RD;
        fill_we       = bus_gnt && write_q;
      end
      default: begin
        fill_we = 1'b1;
        fill_st = bus_shared_in ? ST_S : ST_E;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q        <= F_IDLE;
      addr_q       <= '0;
      write_q      <= 1'b0;
      victim_tag_q <= '0;
      done_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (fsm_q)
        F_IDLE: if (accept) begin
          if (fast) begin
            done_q <= 1'b1;
          end else begin
            addr_q       <= cpu_req_addr;
            write_q      <= cpu_req_write;
            victim_tag_q <= look_tag;
            fsm_q        <= (!hit && look_st == ST_M) ? F_WB : F_REQ;
          end
        end
        F_WB: if (bus_gnt) fsm_q <= F_REQ;
        F_REQ: if (bus_gnt) begin
          if (write_q) begin
            done_q <= 1'b1;
            fsm_q  <= F_IDLE;
          end else begin
            fsm_q  <= F_SAMPLE;
          end
        end
        default: begin
          done_q <= 1'b1;
          fsm_q  <= F_IDLE;
        end
      endcase
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_gnt) |=>
      (bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_kind)));

  // R5
  silent_upgrade_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cpu_req_write && hit && look_st == ST_E) |=>
      (cpu_done && !bus_req_valid));

  // R12
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> !cpu_req_ready);
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SETS   = 4,
  parameter bit C2C_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_done,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_kind,
  output logic [ADDR_W-1:0] bus_req_addr,
  input  logic              bus_gnt,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_kind,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              c2c_pick,
  output logic              snp_shared,
  output logic              snp_flush,
  output logic              snp_supply
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [TAG_W-1:0]      look_tag, snp_line_tag, fill_tag;
  line_st_e              look_st, snp_line_st, fill_st, snp_new_st;
  logic [SETS-1:0][1:0]  st_all;
  logic                  fill_we, snp_we, sampling;
  logic [IDX_W-1:0]      fill_idx;

  mesi_line_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_idx    (cpu_req_addr[IDX_W-1:0]),
    .snp_idx    (snp_addr[IDX_W-1:0]),
    .fill_we    (fill_we),
    .fill_idx   (fill_idx),
    .fill_tag   (fill_tag),
    .fill_st    (fill_st),
    .snp_we     (snp_we),
    .snp_st     (snp_new_st),
    .cpu_tag    (look_tag),
    .cpu_st     (look_st),
    .snp_tag    (snp_line_tag),
    .snp_cur_st (snp_line_st),
    .st_all     (st_all)
  );

  mesi_snoop_resp #(.TAG_W(TAG_W), .C2C_EN(C2C_EN)) u_snoop (
    .clk        (clk),
    .rst_n      (rst_n),
    .snp_valid  (snp_valid),
    .snp_kind   (snp_kind),
    .snp_tag_in (snp_addr[ADDR_W-1:IDX_W]),
    .c2c_pick   (c2c_pick),
    .line_tag   (snp_line_tag),
    .line_st    (snp_line_st),
    .snp_we     (snp_we),
    .snp_new_st (snp_new_st),
    .snp_shared (snp_shared),
    .snp_flush  (snp_flush),
    .snp_supply (snp_supply)
  );

  mesi_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_write (cpu_req_write),
    .cpu_req_addr  (cpu_req_addr),
    .cpu_req_ready (cpu_req_ready),
    .cpu_done      (cpu_done),
    .snp_valid     (snp_valid),
    .bus_gnt       (bus_gnt),
    .bus_shared_in (bus_shared_in),
    .look_tag      (look_tag),
    .look_st       (look_st),
    .bus_req_valid (bus_req_valid),
    .bus_req_kind  (bus_req_kind),
    .bus_req_addr  (bus_req_addr),
    .fill_we       (fill_we),
    .fill_idx      (fill_idx),
    .fill_tag      (fill_tag),
    .fill_st       (fill_st),
    .sampling      (sampling)
  );

  // R3
  shared_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sampling |=> (st_all[$past(fill_idx)] == ($past(bus_shared_in) ? ST_S : ST_E)));

  // R9
  rdx_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_kind == BK_RDX && !fill_we &&
     snp_line_tag == snp_addr[ADDR_W-1:IDX_W]) |=>
      (st_all[$past(snp_addr[IDX_W-1:0])] == ST_I));
endmodule

// File: tb/mesi_snoop_ctrl_test.sv
module mesi_snoop_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [7:0] cpu_req_addr = '0;
  logic       cpu_req_ready, cpu_done;
  logic       bus_req_valid;
  logic [1:0] bus_req_kind;
  logic [7:0] bus_req_addr;
  logic       bus_gnt = 1'b0, bus_shared_in = 1'b0;
  logic       snp_valid = 1'b0, c2c_pick = 1'b0;
  logic [1:0] snp_kind = '0;
  logic [7:0] snp_addr = '0;
  logic       snp_shared, snp_flush, snp_supply;
  int         compared = 0, mismatched = 0;

  always #2 clk = ~clk;

  mesi_snoop_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_done(cpu_done),
    .bus_req_valid(bus_req_valid), .bus_req_kind(bus_req_kind),
    .bus_req_addr(bus_req_addr), .bus_gnt(bus_gnt),
    .bus_shared_in(bus_shared_in),
    .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_addr(snp_addr),
    .c2c_pick(c2c_pick),
    .snp_shared(snp_shared), .snp_flush(snp_flush), .snp_supply(snp_supply)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // accept one request; returns at the falling edge after the accepting edge
  task automatic cpu_issue(input logic w, input logic [7:0] a);
    @(negedge clk);
    check("R12 ready when idle", 32'(cpu_req_ready), 1);
    cpu_req_valid = 1'b1; cpu_req_write = w; cpu_req_addr = a;
    @(negedge clk);
    cpu_req_valid = 1'b0;
  endtask

  task automatic bus_step(input string req, input logic [1:0] kind, input logic [7:0] a,
                          input logic hold);
    check(req, 32'(bus_req_valid), 1);
    check(req, 32'(bus_req_kind), 32'(kind));
    check(req, 32'(bus_req_addr), 32'(a));
    if (hold) begin
      @(negedge clk);
      check("R2 held until grant", {bus_req_valid, bus_req_kind, bus_req_addr}, {1'b1, kind, a});
      check("R12 busy blocks ready", 32'(cpu_req_ready), 0);
    end
    bus_gnt = 1'b1;
    @(negedge clk);
    bus_gnt = 1'b0;
  endtask

  task automatic read_miss(input logic [7:0] a, input logic sh, input logic wb,
                           input logic [7:0] wba);
    cpu_issue(1'b0, a);
    if (wb) bus_step("R11 write-back of dirty victim", 2'd3, wba, 1'b0);
    bus_step("R2 read request", 2'd1, a, 1'b1);
    check("R3 not done before sample", 32'(cpu_done), 0);
    bus_shared_in = sh;
    @(negedge clk);
    bus_shared_in = 1'b0;
    check("R3 done after sample", 32'(cpu_done), 1);
  endtask

  task automatic write_miss(input logic [7:0] a);
    cpu_issue(1'b1, a);
    bus_step("R6 read-exclusive request", 2'd2, a, 1'b0);
    check("R6 done after grant", 32'(cpu_done), 1);
  endtask

  task automatic cpu_hit(input string req, input logic w, input logic [7:0] a);
    cpu_issue(w, a);
    check(req, {cpu_done, bus_req_valid}, 2'b10);
    @(negedge clk);
    check(req, {cpu_done, bus_req_valid}, 2'b00);
  endtask

  task automatic snoop(input string req, input logic [1:0] kind, input logic [7:0] a,
                       input logic pick, input logic [2:0] exp);
    @(negedge clk);
    snp_valid = 1'b1; snp_kind = kind; snp_addr = a; c2c_pick = pick;
    #1 check("R12 snoop blocks ready", 32'(cpu_req_ready), 0);
    check("R7 no early response", {snp_shared, snp_flush, snp_supply}, 0);
    @(negedge clk);
    snp_valid = 1'b0; c2c_pick = 1'b0;
    check(req, {snp_shared, snp_flush, snp_supply}, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared + 1, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset outputs",
          {cpu_req_ready, bus_req_valid, cpu_done, snp_shared, snp_flush, snp_supply}, 6'b100000);
    snoop("R1 all lines invalid", 2'd1, 8'h10, 1'b1, 3'b000);

    // read miss alone -> Exclusive, snoops walk E -> S
    read_miss(8'h10, 1'b0, 1'b0, 8'h00);
    snoop("R10 exclusive supplies", 2'd1, 8'h10, 1'b0, 3'b101);
    snoop("R8 exclusive became shared", 2'd1, 8'h10, 1'b0, 3'b100);
    snoop("R10 shared supplies when picked", 2'd1, 8'h10, 1'b1, 3'b101);

    // hits and upgrade
    cpu_hit("R4 read hit in shared", 1'b0, 8'h10);
    write_miss(8'h10);
    cpu_hit("R4 write hit in modified", 1'b1, 8'h10);
    cpu_hit("R4 read hit in modified", 1'b0, 8'h10);
    snoop("R8 modified flushes on read", 2'd1, 8'h10, 1'b1, 3'b110);
    snoop("R8 modified became shared", 2'd1, 8'h10, 1'b0, 3'b100);

    // read miss with shared line high -> Shared, then invalidated
    read_miss(8'h21, 1'b1, 1'b0, 8'h00);
    snoop("R3 shared fill", 2'd1, 8'h21, 1'b0, 3'b100);
    snoop("R9 shared invalidated quietly", 2'd2, 8'h21, 1'b0, 3'b000);
    snoop("R9 line now invalid", 2'd1, 8'h21, 1'b1, 3'b000);

    // silent E -> M upgrade
    read_miss(8'h22, 1'b0, 1'b0, 8'h00);
    cpu_hit("R5 write hit in exclusive no bus", 1'b1, 8'h22);
    cpu_hit("R4 read hit in exclusive-upgraded", 1'b0, 8'h22);
    snoop("R9 modified flushes on read-exclusive", 2'd2, 8'h22, 1'b0, 3'b010);
    snoop("R9 line now invalid", 2'd1, 8'h22, 1'b0, 3'b000);

    // replacement
    write_miss(8'h13);
    snoop("R7 tag mismatch no response", 2'd1, 8'h27, 1'b1, 3'b000);
    read_miss(8'h27, 1'b0, 1'b1, 8'h13);
    snoop("R11 victim gone", 2'd1, 8'h13, 1'b0, 3'b000);
    read_miss(8'h33, 1'b0, 1'b0, 8'h00);
    snoop("R11 clean victim dropped", 2'd1, 8'h27, 1'b0, 3'b000);
    snoop("R11 new line exclusive", 2'd1, 8'h33, 1'b0, 3'b101);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule